// File: doc/BRIEF.md
# Three-Operand Adder with Carry-Bypass Stall

The block adds three wide operands in one arithmetic step, producing Z + a·C + b·N, where each of the signs a and b is −1, 0 or +1. A carry-save stage first folds the three operands into a sum vector and a carry vector. A carry-propagate stage then resolves them through bit slices. Each slice is classed as kill, generate or propagate. The slices are grouped into 4-bit blocks that carry bypass paths, and those blocks are grouped again into 16-bit blocks.

The block does not clock at the rate set by a worst-case ripple. Instead it inspects the propagate pattern of each 16-bit block when an operation is accepted. A single fully propagating 16-bit block raises a panic, and the result is held back by a short parameterised wait. Two neighbouring fully propagating blocks raise a double panic, and the result is held back by a longer wait that covers a ripple across the whole width. A carry-disable input turns the adder into a carry-free XOR combiner for binary-polynomial arithmetic. In that mode no carry can travel, so no stall is ever taken.

Top module: `tri_add_stall`

## Requirements
- R1: While rst is high and after it falls, busy, valid, panic and dpanic are low and sum is zero until the first accepted start.
- R2: With carry_off low, sum equals (Z + a·C + b·N) mod 2^W, where the sign codes are 2'b00 = 0, 2'b01 = +1, 2'b11 = −1, and 2'b10 behaves as 0.
- R3: With carry_off high, sum equals Z XOR (C if a ≠ 0) XOR (N if b ≠ 0), where a code of 2'b01 or 2'b11 counts as nonzero.
- R4: Slice propagate is p = s XOR cv. Here s is the bitwise XOR of Z and the selected C and N terms. An operand with sign −1 is bit-inverted. cv is the majority of those three terms shifted up one bit, with bit 0 set when a = −1. A 16-bit block (bits 16k..16k+15) is active when all of its p bits are 1. With carry_off low, panic is 1 exactly when at least one block is active.
- R5: dpanic is 1 exactly when two blocks k and k+1 are both active (carry_off low). dpanic never appears without panic.
- R6: With carry_off high, panic and dpanic are 0 and no stall is taken, whatever the operands.
- R7: A start accepted at a clock edge yields a single-cycle valid pulse 1 + w edges later. Here w = 0 normally, P1 on panic only, and P2 on double panic.
- R8: busy is high from the edge that accepts a start until the edge that raises valid. A start seen while busy is ignored and produces no result.
- R9: sum keeps its value until the next result. panic and dpanic change only when a start is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Accept new operands when not busy |
| carry_off | input | 1 | Binary-polynomial mode: carries suppressed |
| op_z | input | W | Accumulator operand Z |
| op_c | input | W | Operand C |
| op_n | input | W | Operand N |
| sgn_a | input | 2 | Sign code applied to C |
| sgn_b | input | 2 | Sign code applied to N |
| sum | output | W | Registered result |
| busy | output | 1 | Operation in progress or stalled |
| valid | output | 1 | One-cycle pulse: sum is new |
| panic | output | 1 | At least one 16-bit block fully propagating |
| dpanic | output | 1 | Two neighbouring 16-bit blocks fully propagating |

## Verification
A result is due 1, 1+P1 or 1+P2 edges after the edge that takes start, depending on the panic class predicted from the operands. The flags are due one edge after the start. The bench stamps each queued expectation with the cycle count at which start was driven. The monitor, sampling on the falling edge, compares the elapsed count against 2 + w when valid appears, so a result that arrives early or late is a mismatch. A start issued mid-stall must leave the queue untouched, and any valid that arrives with the queue empty is reported.

// File: rtl/tri_add_pkg.sv
package tri_add_pkg;
  typedef enum logic [1:0] {
    SG_ZERO = 2'b00,
    SG_POS  = 2'b01,
    SG_RSV  = 2'b10,
    SG_NEG  = 2'b11
  } sign_e;

  localparam int BLK_WIDE = 16;
  localparam int BLK_SKIP = 4;
endpackage

// File: rtl/tri_add_csa.sv
module tri_add_csa
  import tri_add_pkg::*;
#(
  parameter int W = 64
) (
  input  logic [W-1:0] z,
  input  logic [W-1:0] c,
  input  logic [W-1:0] n,
  input  logic [1:0]   sa,
  input  logic [1:0]   sb,
  input  logic         carry_off,
  output logic [W-1:0] s,
  output logic [W-1:0] cv,
  output logic         cin
);
  logic [W-1:0] tc, tn, maj;

  always_comb begin
    case (sign_e'(sa))
      SG_POS:  tc = c;
      SG_NEG:  tc = carry_off ? c : ~c;
      default: tc = '0;
    endcase
    case (sign_e'(sb))
      SG_POS:  tn = n;
      SG_NEG:  tn = carry_off ? n : ~n;
      default: tn = '0;
    endcase
    s   = z ^ tc ^ tn;
    maj = (z & tc) | (z & tn) | (tc & tn);
    if (carry_off) begin
      cv  = '0;
      cin = 1'b0;
    end else begin
      cv  = {maj[W-2:0], (sa == SG_NEG)};
      cin = (sb == SG_NEG);
    end
  end
endmodule

// File: rtl/tri_add_detect.sv
module tri_add_detect
  import tri_add_pkg::*;
#(
  parameter int W = 64
) (
  input  logic [W-1:0] s,
  input  logic [W-1:0] cv,
  input  logic         carry_off,
  output logic         panic,
  output logic         dpanic
);
  localparam int NB = W / BLK_WIDE;

  logic [W-1:0]  p;
  logic [NB-1:0] act;

  assign p = s ^ cv;

  for (genvar k = 0; k < NB; k++) begin : g_blk
    assign act[k] = &p[k*BLK_WIDE +: BLK_WIDE];
  end

  always_comb begin
    logic pair;
    pair = 1'b0;
    for (int k = 0; k + 1 < NB; k++) pair = pair | (act[k] & act[k+1]);
    panic  = ~carry_off & (|act);
    dpanic = ~carry_off & pair;
  end
endmodule

// File: rtl/tri_add_cpa.sv
module tri_add_cpa
  import tri_add_pkg::*;
#(
  parameter int W = 64
) (
  input  logic [W-1:0] s,
  input  logic [W-1:0] cv,
  input  logic         cin,
  output logic [W-1:0] sum
);
  localparam int NS = W / BLK_SKIP;

  logic [W-1:0] p, g;
  assign p = s ^ cv;
  assign g = s & cv;

  always_comb begin
    logic cy, cb, pall;
    cy  = cin;
    sum = '0;
    for (int b = 0; b < NS; b++) begin
      cb   = cy;
      pall = 1'b1;
      for (int i = b*BLK_SKIP; i < (b+1)*BLK_SKIP; i++) begin
        sum[i] = p[i] ^ cy;
        cy     = g[i] | (p[i] & cy);
        pall   = pall & p[i];
      end
      if (pall) cy = cb;
    end
  end
endmodule

// File: rtl/tri_add_stall.sv
module tri_add_stall
  import tri_add_pkg::*;
#(
  parameter int W  = 64,
  parameter int P1 = 2,
  parameter int P2 = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic         carry_off,
  input  logic [W-1:0] op_z,
  input  logic [W-1:0] op_c,
  input  logic [W-1:0] op_n,
  input  logic [1:0]   sgn_a,
  input  logic [1:0]   sgn_b,
  output logic [W-1:0] sum,
  output logic         busy,
  output logic         valid,
  output logic         panic,
  output logic         dpanic
);
  localparam int CW = $clog2(P2 + 1) + 1;

  logic [W-1:0]  s_d, cv_d, s_q, cv_q, sum_d;
  logic          cin_d, cin_q, pn_d, dp_d;
  logic [CW-1:0] cnt;

  tri_add_csa #(.W(W)) u_csa (
    .z(op_z), .c(op_c), .n(op_n), .sa(sgn_a), .sb(sgn_b),
    .carry_off(carry_off), .s(s_d), .cv(cv_d), .cin(cin_d)
  );

  tri_add_detect #(.W(W)) u_det (
    .s(s_d), .cv(cv_d), .carry_off(carry_off), .panic(pn_d), .dpanic(dp_d)
  );

  tri_add_cpa #(.W(W)) u_cpa (
    .s(s_q), .cv(cv_q), .cin(cin_q), .sum(sum_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      s_q    <= '0;
      cv_q   <= '0;
      cin_q  <= 1'b0;
      cnt    <= '0;
      busy   <= 1'b0;
      valid  <= 1'b0;
      panic  <= 1'b0;
      dpanic <= 1'b0;
      sum    <= '0;
    end else begin
      valid <= 1'b0;
      if (!busy && start) begin
        s_q    <= s_d;
        cv_q   <= cv_d;
        cin_q  <= cin_d;
        panic  <= pn_d;
        dpanic <= dp_d;
        busy   <= 1'b1;
        cnt    <= dp_d ? CW'(P2) : (pn_d ? CW'(P1) : '0);
      end else if (busy) begin
        if (cnt == '0) begin
          sum   <= sum_d;
          valid <= 1'b1;
          busy  <= 1'b0;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/tri_add_stall_chk.sv
module tri_add_stall_chk #(
  parameter int P1 = 2,
  parameter int P2 = 6
) (
  input logic clk,
  input logic rst,
  input logic start,
  input logic carry_off,
  input logic busy,
  input logic valid,
  input logic panic,
  input logic dpanic
);
  int blen;

  always_ff @(posedge clk) begin
    if (rst) blen <= 0;
    else     blen <= busy ? blen + 1 : 0;
  end

  AST_DPANIC_NEEDS_PANIC: assert property (@(posedge clk) disable iff (rst)
    dpanic |-> panic); // R5
  AST_CARRYOFF_NO_FLAG: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) && $past(carry_off) |-> !panic && !dpanic); // R6
  AST_QUICK_RESULT: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) && !panic |=> valid); // R7
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
    valid |=> !valid); // R7
  AST_STALL_LENGTH: assert property (@(posedge clk) disable iff (rst)
    valid |-> blen == (dpanic ? P2 : (panic ? P1 : 0)) + 1); // R7
  AST_BUSY_FROM_START: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start)); // R8
  AST_VALID_ENDS_BUSY: assert property (@(posedge clk) disable iff (rst)
    valid |-> !busy && $past(busy)); // R8
  AST_FLAGS_HELD: assert property (@(posedge clk) disable iff (rst)
    busy && $past(busy) |-> $stable(panic) && $stable(dpanic)); // R9
endmodule

bind tri_add_stall tri_add_stall_chk #(.P1(P1), .P2(P2)) u_chk (
  .clk(clk), .rst(rst), .start(start), .carry_off(carry_off),
  .busy(busy), .valid(valid), .panic(panic), .dpanic(dpanic)
);

// File: tb/test_tri_add_stall.sv
module test_tri_add_stall;
  localparam int W = 64;
  localparam int P1 = 2;
  localparam int P2 = 6;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst = 1, start = 0, carry_off = 0;
  logic [W-1:0] op_z = '0, op_c = '0, op_n = '0;
  logic [1:0] sgn_a = 0, sgn_b = 0;
  logic [W-1:0] sum;
  logic busy, valid, panic, dpanic;

  int n_chk = 0, n_bad = 0, cyc = 0;

  typedef struct {
    logic [W-1:0] sum;
    logic pn, dp;
    int lat, t0;
    bit co;
  } item_t;
  item_t q[$];

  tri_add_stall #(.W(W), .P1(P1), .P2(P2)) i_tri_add_stall (
    .clk(clk), .rst(rst), .start(start), .carry_off(carry_off),
    .op_z(op_z), .op_c(op_c), .op_n(op_n), .sgn_a(sgn_a), .sgn_b(sgn_b),
    .sum(sum), .busy(busy), .valid(valid), .panic(panic), .dpanic(dpanic)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] term(input logic [W-1:0] v, input logic [1:0] sg, input bit co);
    if (sg == 2'b01) return v;
    if (sg == 2'b11) return co ? v : ~v;
    return '0;
  endfunction

  // Expected value from R2/R3, flags from the R4/R5 propagate definition.
  task automatic do_op(input logic [W-1:0] z, c, n, input logic [1:0] a, b, input bit co);
    item_t it;
    logic [W-1:0] tc, tn, s, cv, p;
    logic [W/16-1:0] act;
    tc = term(c, a, co);
    tn = term(n, b, co);
    if (co) it.sum = z ^ tc ^ tn;
    else it.sum = z + (a == 2'b01 ? c : (a == 2'b11 ? -c : '0))
                    + (b == 2'b01 ? n : (b == 2'b11 ? -n : '0));
    s  = z ^ tc ^ tn;
    cv = {((z & tc) | (z & tn) | (tc & tn)), 1'b0};
    cv[0] = (a == 2'b11);
    p = co ? s : s ^ cv;
    for (int k = 0; k < W/16; k++) act[k] = &p[k*16 +: 16];
    it.pn = !co && (act != 0);
    it.dp = 0;
    for (int k = 0; k + 1 < W/16; k++) if (!co && act[k] && act[k+1]) it.dp = 1;
    it.lat = 2 + (it.dp ? P2 : (it.pn ? P1 : 0));
    it.co = co;
    @(negedge clk);
    op_z = z; op_c = c; op_n = n; sgn_a = a; sgn_b = b; carry_off = co;
    start = 1;
    it.t0 = cyc;
    q.push_back(it);
    @(negedge clk);
    start = 0;
    chk(busy === 1'b1, "R8 busy after start", W'(busy), W'(1));
    wait (q.size() == 0);
  endtask

  // Monitor: pop and compare on every valid pulse.
  always @(negedge clk) begin
    if (!rst && valid) begin
      if (q.size() == 0) begin
        chk(0, "R8 unexpected result", sum, '0);
      end else begin
        item_t e;
        e = q.pop_front();
        chk(sum === e.sum, e.co ? "R3 xor sum" : "R2 modular sum", sum, e.sum);
        chk(panic === e.pn, e.co ? "R6 panic" : "R4 panic", W'(panic), W'(e.pn));
        chk(dpanic === e.dp, e.co ? "R6 dpanic" : "R5 dpanic", W'(dpanic), W'(e.dp));
        chk(cyc - e.t0 == e.lat, "R7 latency", W'(cyc - e.t0), W'(e.lat));
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [W-1:0] held;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(busy === 0 && valid === 0 && panic === 0 && dpanic === 0, "R1 flags after reset",
        W'({busy, valid, panic, dpanic}), '0);
    chk(sum === '0, "R1 sum after reset", sum, '0);

    // R2 sign combinations
    do_op(64'd100, 64'd7, 64'd3, 2'b01, 2'b01, 0);
    do_op(64'd100, 64'd7, 64'd3, 2'b11, 2'b01, 0);
    do_op(64'd5, 64'd9, 64'd30, 2'b01, 2'b11, 0);
    do_op(64'd5, 64'd9, 64'd30, 2'b10, 2'b00, 0);
    do_op('1, 64'd1, 64'd0, 2'b01, 2'b00, 0);
    // R4 single block, R5 neighbours / non-neighbours
    do_op(64'h0000_0000_0000_FFFF, 0, 0, 2'b00, 2'b00, 0);
    do_op(64'h0000_0000_FFFF_FFFF, 0, 0, 2'b00, 2'b00, 0);
    do_op(64'hFFFF_0000_FFFF_0000, 0, 0, 2'b00, 2'b00, 0);
    do_op('1, 64'd1, 0, 2'b11, 2'b00, 0);
    // R3, R6 binary mode
    do_op(64'h0F0F_1234_FFFF_FFFF, 64'h00FF_0000_1111_0000, 64'hA5A5_5A5A_0000_FFFF, 2'b11, 2'b01, 1);
    do_op('1, 64'hFF, 64'h3, 2'b00, 2'b10, 1);

    // R8 start during a double-panic stall is ignored; R9 sum held afterwards
    begin
      item_t it;
      do_op(64'hFFFF_FFFF_0000_0000, 64'd0, 64'd0, 2'b00, 2'b00, 0);
    end
    @(negedge clk);
    op_z = 64'hFFFF_FFFF_FFFF_0000; sgn_a = 2'b00; sgn_b = 2'b00; carry_off = 0;
    begin
      item_t it;
      it.sum = 64'hFFFF_FFFF_FFFF_0000; it.pn = 1; it.dp = 1; it.lat = 2 + P2; it.co = 0;
      start = 1; it.t0 = cyc; q.push_back(it);
      @(negedge clk); start = 0;
      op_z = 64'h1234; start = 1;
      @(negedge clk); start = 0;
      chk(busy === 1'b1, "R8 busy during stall", W'(busy), W'(1));
      wait (q.size() == 0);
    end
    repeat (P2 + 4) @(negedge clk);
    chk(sum === 64'hFFFF_FFFF_FFFF_0000, "R9 sum held", sum, 64'hFFFF_FFFF_FFFF_0000);
    chk(busy === 1'b0, "R8 ignored start left idle", W'(busy), '0);
    held = sum;

    // Random operands, some with forced all-ones regions
    for (int r = 0; r < 60; r++) begin
      logic [W-1:0] z, c, n;
      z = {$urandom, $urandom}; c = {$urandom, $urandom}; n = {$urandom, $urandom};
      if (r % 4 == 1) z[31:0] = '1;
      if (r % 4 == 2) z = z | 64'hFFFF_FFFF_0000_0000;
      if (r % 4 == 3) begin c = 0; n = 0; z[47:16] = '1; end
      do_op(z, c, n, 2'($urandom), 2'($urandom), (r % 7 == 0));
    end
    repeat (4) @(negedge clk);
    chk(q.size() == 0, "R7 all results delivered", W'(q.size()), '0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule